// File: doc/BRIEF.md
# Dual-Antenna Packet Detect Qualifier

This block sits behind the raw packet-detect sources of a two-antenna receiver and decides when a packet start is really declared. Each cycle is one sample. Each antenna delivers an auto-correlation ratio and a power value. An antenna registers a hit when both values reach their programmed thresholds. Two further sources can also raise a raw detect: a one-bit energy-threshold event and a one-bit external detect input. A 10-bit control word picks the sources and antennas that count. It also sets whether the two antenna hits combine with OR, or with AND inside an 8-sample window.

A raw detect can be declared at once, or held as a candidate until one or two long-correlation hits confirm it. A candidate that gets no confirmation within 256 samples is dropped, and the block re-arms. A declared detect gives a single-cycle pulse and raises a busy flag. The flag stays up until the receiver signals done, or until the control word's master-reset bit is set.

The controller has four states. ST_IDLE waits for a raw detect. ST_CONF1 waits for the first long-correlation hit. ST_CONF2 waits for the second hit. ST_HELD is the busy state.

The transitions are:
- idle-to-held: a raw detect with no confirmation required.
- idle-to-conf1: a raw detect with confirmation required.
- conf1-to-conf2: the first hit arrives and two hits are required.
- conf1-to-held: the first hit arrives and one hit is required.
- conf2-to-held: the second hit arrives.
- conf-to-idle: the timeout expires.
- held-to-idle: done is asserted.
- any-to-idle: the master-reset bit is set.

Top module: `pd_qualifier`

## Requirements
- R1: After rst_n is released, det_pulse and busy are 0 until a qualifying event occurs.
- R2: An antenna hit requires the ratio to be at or above ratio_thr AND the power to be at or above power_min. Either value one below its threshold gives no hit.
- R3: With ctrl_word bit 4 = 1 (OR mode), an accepted hit on either antenna alone is a raw detect.
- R4: With ctrl_word bit 4 = 0 (AND mode), a raw detect needs hits on both antennas whose sample times differ by at most 7. A spacing of 8 gives no detect. A raw detect clears the pairing history.
- R5: Hits on antenna A count only with ctrl_word bit 5 = 1, and hits on antenna B only with bit 6 = 1. Neither antenna counts unless bit 9 (auto-correlation enable) = 1.
- R6: energy_det is a raw detect only when ctrl_word bit 8 = 1. ext_det is a raw detect only when bit 7 = 1.
- R7: With ctrl_word bit 1 = 1, no source produces a raw detect.
- R8: With lc_need_one = 1 (and lc_need_two = 0), a raw detect is declared only after one long_corr_hit in a later cycle. long_corr_hit while idle has no effect.
- R9: With lc_need_two = 1, two long_corr_hit cycles are needed before the detect is declared.
- R10: Confirmation hits count only in the 256 samples that follow the raw detect. Without them, the candidate is dropped, the block returns to idle, and it produces no pulse.
- R11: A declared detect gives det_pulse = 1 for exactly one cycle, in the cycle after the deciding sample, and busy = 1 from that cycle. Busy holds until the cycle after rx_done, and new events meanwhile are ignored.
- R12: With ctrl_word bit 0 = 1, the block returns to idle at the next clock edge. busy and det_pulse are then 0 and pairing history is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_word | input | 10 | Control word (bit 0 master reset, 1 ignore, 4 OR mode, 5/6 accept A/B, 7 external, 8 energy, 9 auto-correlation) |
| lc_need_one | input | 1 | Require one long-correlation confirmation |
| lc_need_two | input | 1 | Require two long-correlation confirmations |
| ratio_thr | input | 8 | Minimum correlation/power ratio (unsigned, 7 fractional bits) |
| power_min | input | 16 | Minimum power for an antenna hit |
| ac_ratio_a | input | 8 | Antenna A correlation/power ratio |
| ac_power_a | input | 16 | Antenna A power |
| ac_ratio_b | input | 8 | Antenna B correlation/power ratio |
| ac_power_b | input | 16 | Antenna B power |
| energy_det | input | 1 | Energy-threshold detect event |
| ext_det | input | 1 | External detect event |
| long_corr_hit | input | 1 | Long-correlation hit |
| rx_done | input | 1 | Receiver done; releases busy |
| det_pulse | output | 1 | Qualified detect pulse |
| busy | output | 1 | Detect held, awaiting done |

## Verification
Some properties are checked by assertions on every cycle:
- the pulse is one cycle wide and always coincides with busy;
- busy persists until done or master reset;
- a pulse that follows a candidate state was preceded by a long-correlation hit;
- an AND-mode pairing event always contains a live antenna hit.

Other behaviour shows only in the bench's scenarios, run against the reference model:
- the exact 7-versus-8 sample pairing boundary;
- the last accepted confirmation sample of the 256-sample window;
- threshold equality on ratio and power;
- the effect of each source-enable and accept bit.

// File: rtl/pd_pkg.sv
`timescale 1ns/1ps
package pd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CONF1 = 2'd1,
        ST_CONF2 = 2'd2,
        ST_HELD  = 2'd3
    } qual_state_e;

    localparam int CB_MRST   = 0;
    localparam int CB_IGNORE = 1;
    localparam int CB_OR     = 4;
    localparam int CB_ACC_A  = 5;
    localparam int CB_ACC_B  = 6;
    localparam int CB_EXT    = 7;
    localparam int CB_ENERGY = 8;
    localparam int CB_ACORR  = 9;
    localparam int CTRL_W    = 10;
endpackage

// File: rtl/pd_ant_cmp.sv
`timescale 1ns/1ps
module pd_ant_cmp #(
    parameter int RATIO_W = 8,
    parameter int POWER_W = 16
) (
    input  logic               enable,
    input  logic [RATIO_W-1:0] ratio,
    input  logic [POWER_W-1:0] power,
    input  logic [RATIO_W-1:0] ratio_thr,
    input  logic [POWER_W-1:0] power_min,
    output logic               hit
);
    always_comb begin
        hit = enable && (ratio >= ratio_thr) && (power >= power_min);
    end
endmodule

// File: rtl/pd_pair_comb.sv
`timescale 1ns/1ps
module pd_pair_comb #(
    parameter int WIN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic or_mode,
    input  logic hit_a,
    input  logic hit_b,
    output logic evt
);
    localparam int CW = (WIN > 2) ? $clog2(WIN) : 1;

    logic [1:0]    hits;
    logic [1:0]    recent;
    logic [CW-1:0] age [2];

    assign hits = {hit_b, hit_a};

    always_comb begin
        if (or_mode)
            evt = hit_a | hit_b;
        else
            evt = (hit_a & (hit_b | recent[1])) | (hit_b & recent[0]);
    end

    for (genvar g = 0; g < 2; g++) begin : g_age
        assign recent[g] = (age[g] != '0);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                age[g] <= '0;
            else if (clr || evt)
                age[g] <= '0;
            else if (hits[g])
                age[g] <= CW'(WIN - 1);
            else if (recent[g])
                age[g] <= age[g] - 1'b1;
        end
    end

    // R4
    and_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!or_mode && evt) |-> (hit_a || hit_b));
endmodule

// File: rtl/pd_qual_fsm.sv
`timescale 1ns/1ps
module pd_qual_fsm
    import pd_pkg::*;
#(
    parameter int TMO = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic raw_det,
    input  logic lc_hit,
    input  logic need_one,
    input  logic need_two,
    input  logic done,
    output logic det_pulse,
    output logic busy
);
    localparam int TW = (TMO > 2) ? $clog2(TMO) : 1;
    localparam logic [TW-1:0] T_LAST = TW'(TMO - 1);

    qual_state_e   state, nxt_state;
    logic [TW-1:0] timer, nxt_timer;
    logic          declare;
    logic          pulse_q;

    always_comb begin
        nxt_state = state;
        nxt_timer = timer;
        declare   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                nxt_timer = '0;
                if (raw_det) begin
                    if (need_one || need_two) begin
                        nxt_state = ST_CONF1;
                    end else begin
                        nxt_state = ST_HELD;
                        declare   = 1'b1;
                    end
                end
            end
            ST_CONF1: begin
                nxt_timer = timer + 1'b1;
                if (lc_hit) begin
                    if (need_two) begin
                        nxt_state = ST_CONF2;
                    end else begin
                        nxt_state = ST_HELD;
                        declare   = 1'b1;
                    end
                end else if (timer == T_LAST) begin
                    nxt_state = ST_IDLE;
                end
            end
            ST_CONF2: begin
                nxt_timer = timer + 1'b1;
                if (lc_hit) begin
                    nxt_state = ST_HELD;
                    declare   = 1'b1;
                end else if (timer == T_LAST) begin
                    nxt_state = ST_IDLE;
                end
            end
            ST_HELD: begin
                if (done)
                    nxt_state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            timer <= '0;
        end else if (clr) begin
            state <= ST_IDLE;
            timer <= '0;
        end else begin
            state <= nxt_state;
            timer <= nxt_timer;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pulse_q <= 1'b0;
        else
            pulse_q <= declare && !clr;
    end

    assign det_pulse = pulse_q;
    assign busy      = (state == ST_HELD);

    // R11
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        det_pulse |=> !det_pulse);
    // R11
    pulse_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        det_pulse |-> busy);
    // R11
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && !clr) |=> busy);
    // R8
    lc_confirm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (det_pulse && $past(state) != ST_IDLE) |-> $past(lc_hit));
    // R12
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!busy && !det_pulse));
endmodule

// File: rtl/pd_qualifier.sv
`timescale 1ns/1ps
module pd_qualifier
    import pd_pkg::*;
#(
    parameter int RATIO_W = 8,
    parameter int POWER_W = 16,
    parameter int WIN     = 8,
    parameter int TMO     = 256
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CTRL_W-1:0]  ctrl_word,
    input  logic               lc_need_one,
    input  logic               lc_need_two,
    input  logic [RATIO_W-1:0] ratio_thr,
    input  logic [POWER_W-1:0] power_min,
    input  logic [RATIO_W-1:0] ac_ratio_a,
    input  logic [POWER_W-1:0] ac_power_a,
    input  logic [RATIO_W-1:0] ac_ratio_b,
    input  logic [POWER_W-1:0] ac_power_b,
    input  logic               energy_det,
    input  logic               ext_det,
    input  logic               long_corr_hit,
    input  logic               rx_done,
    output logic               det_pulse,
    output logic               busy
);
    logic [RATIO_W-1:0] ratio_v [2];
    logic [POWER_W-1:0] power_v [2];
    logic [1:0]         accept;
    logic [1:0]         ant_hit;
    logic               pair_evt;
    logic               raw_det;
    logic               clr;

    assign ratio_v[0] = ac_ratio_a;
    assign ratio_v[1] = ac_ratio_b;
    assign power_v[0] = ac_power_a;
    assign power_v[1] = ac_power_b;
    assign accept     = {ctrl_word[CB_ACC_B], ctrl_word[CB_ACC_A]};
    assign clr        = ctrl_word[CB_MRST];

    for (genvar g = 0; g < 2; g++) begin : g_ant
        pd_ant_cmp #(.RATIO_W(RATIO_W), .POWER_W(POWER_W)) u_cmp (
            .enable    (ctrl_word[CB_ACORR] & accept[g]),
            .ratio     (ratio_v[g]),
            .power     (power_v[g]),
            .ratio_thr (ratio_thr),
            .power_min (power_min),
            .hit       (ant_hit[g])
        );
    end

    pd_pair_comb #(.WIN(WIN)) u_pair (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .or_mode (ctrl_word[CB_OR]),
        .hit_a   (ant_hit[0]),
        .hit_b   (ant_hit[1]),
        .evt     (pair_evt)
    );

    always_comb begin
        raw_det = !ctrl_word[CB_IGNORE] &&
                  (pair_evt ||
                   (ctrl_word[CB_ENERGY] && energy_det) ||
                   (ctrl_word[CB_EXT] && ext_det));
    end

    pd_qual_fsm #(.TMO(TMO)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .raw_det   (raw_det),
        .lc_hit    (long_corr_hit),
        .need_one  (lc_need_one),
        .need_two  (lc_need_two),
        .done      (rx_done),
        .det_pulse (det_pulse),
        .busy      (busy)
    );
endmodule

// File: tb/pd_qualifier_tb.sv
`timescale 1ns/1ps
module pd_qualifier_tb;
    localparam int C_MR  = 1 << 0;
    localparam int C_IGN = 1 << 1;
    localparam int C_OR  = 1 << 4;
    localparam int C_A   = 1 << 5;
    localparam int C_B   = 1 << 6;
    localparam int C_EXT = 1 << 7;
    localparam int C_EN  = 1 << 8;
    localparam int C_AC  = 1 << 9;
    localparam int THR   = 90;
    localparam int PMIN  = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  ctrl_word = '0;
    logic        lc_need_one = 1'b0, lc_need_two = 1'b0;
    logic [7:0]  ratio_thr = 8'(THR);
    logic [15:0] power_min = 16'(PMIN);
    logic [7:0]  ac_ratio_a = '0, ac_ratio_b = '0;
    logic [15:0] ac_power_a = '0, ac_power_b = '0;
    logic        energy_det = 1'b0, ext_det = 1'b0, long_corr_hit = 1'b0, rx_done = 1'b0;
    logic        det_pulse, busy;

    int errors = 0;
    int checks = 0;
    int pulses = 0;
    int base   = 0;

    always #5 clk = ~clk;

    pd_qualifier u_dut (
        .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word),
        .lc_need_one(lc_need_one), .lc_need_two(lc_need_two),
        .ratio_thr(ratio_thr), .power_min(power_min),
        .ac_ratio_a(ac_ratio_a), .ac_power_a(ac_power_a),
        .ac_ratio_b(ac_ratio_b), .ac_power_b(ac_power_b),
        .energy_det(energy_det), .ext_det(ext_det),
        .long_corr_hit(long_corr_hit), .rx_done(rx_done),
        .det_pulse(det_pulse), .busy(busy)
    );

    // Behavioural reference model: timestamps of antenna hits, candidate start time
    int cyc = 0;
    int last_a = -100, last_b = -100;
    int m_st = 0;            // 0 idle, 1 waiting confirmation, 3 held
    int m_start = 0, m_hits = 0;
    bit exp_pulse = 0;

    always @(posedge clk) begin
        bit ha, hb, ok_a, ok_b, pair, raw;
        if (!rst_n || ctrl_word[0]) begin
            m_st = 0; last_a = -100; last_b = -100; exp_pulse = 0;
        end else begin
            ha = ctrl_word[9] && ctrl_word[5] && (int'(ac_ratio_a) >= int'(ratio_thr)) &&
                 (int'(ac_power_a) >= int'(power_min));
            hb = ctrl_word[9] && ctrl_word[6] && (int'(ac_ratio_b) >= int'(ratio_thr)) &&
                 (int'(ac_power_b) >= int'(power_min));
            ok_a = (last_a >= 0) && (cyc - last_a <= 7);
            ok_b = (last_b >= 0) && (cyc - last_b <= 7);
            if (ctrl_word[4]) pair = ha || hb;
            else              pair = (ha && (hb || ok_b)) || (hb && ok_a);
            if (pair) begin
                last_a = -100; last_b = -100;
            end else begin
                if (ha) last_a = cyc;
                if (hb) last_b = cyc;
            end
            raw = !ctrl_word[1] && (pair || (ctrl_word[8] && energy_det) || (ctrl_word[7] && ext_det));
            exp_pulse = 0;
            case (m_st)
                0: if (raw) begin
                    if (lc_need_one || lc_need_two) begin
                        m_st = 1; m_start = cyc; m_hits = 0;
                    end else begin
                        m_st = 3; exp_pulse = 1;
                    end
                end
                1: if (long_corr_hit) begin
                    m_hits++;
                    if (!(lc_need_two && m_hits < 2)) begin
                        m_st = 3; exp_pulse = 1;
                    end
                end else if (cyc - m_start >= 256) begin
                    m_st = 0;
                end
                3: if (rx_done) m_st = 0;
                default: m_st = 0;
            endcase
        end
        cyc++;
        if (det_pulse === 1'b1) pulses++;
    end

    always @(negedge clk) begin
        checks++;
        if (det_pulse !== exp_pulse || busy !== (m_st == 3)) begin
            errors++;
            $display("FAIL model R11 cycle %0d: pulse=%0b busy=%0b expected pulse=%0b busy=%0b",
                     cyc, det_pulse, busy, exp_pulse, (m_st == 3));
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic expect_det(input string tag, input int exp_p, input bit exp_busy);
        chk((pulses - base) == exp_p, {tag, " pulses"}, pulses - base, exp_p);
        chk(busy === exp_busy, {tag, " busy"}, int'(busy), int'(exp_busy));
        base = pulses;
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic quiet();
        ac_ratio_a = '0; ac_power_a = '0; ac_ratio_b = '0; ac_power_b = '0;
        energy_det = 0; ext_det = 0; long_corr_hit = 0; rx_done = 0;
    endtask

    // src: 0 antenna A, 1 antenna B, 2 both, 3 energy, 4 external, 5 long correlation
    task automatic fire(input int src);
        if (src == 0 || src == 2) begin ac_ratio_a = 8'(THR); ac_power_a = 16'(PMIN); end
        if (src == 1 || src == 2) begin ac_ratio_b = 8'(THR); ac_power_b = 16'(PMIN); end
        if (src == 3) energy_det = 1;
        if (src == 4) ext_det = 1;
        if (src == 5) long_corr_hit = 1;
        @(negedge clk);
        quiet();
    endtask

    task automatic release_busy();
        rx_done = 1;
        @(negedge clk);
        rx_done = 0;
        tick(10);
        base = pulses;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        tick(3);
        expect_det("R1 reset", 0, 0);
        rst_n = 1;
        tick(3);
        expect_det("R1 after reset", 0, 0);

        // R3 OR mode
        ctrl_word = 10'(C_AC | C_A | C_B | C_OR);
        fire(0); tick(2); expect_det("R3 antenna A alone", 1, 1);
        release_busy();
        fire(1); tick(2); expect_det("R3 antenna B alone", 1, 1);
        release_busy();

        // R2 thresholds
        ac_ratio_a = 8'(THR - 1); ac_power_a = 16'(PMIN); tick(1); quiet();
        ac_ratio_a = 8'(THR); ac_power_a = 16'(PMIN - 1); tick(1); quiet();
        tick(2); expect_det("R2 below threshold", 0, 0);
        ac_ratio_a = 8'hFF; ac_power_a = 16'hFFFF; tick(1); quiet();
        tick(2); expect_det("R2 at/above threshold", 1, 1);
        release_busy();

        // R5 accept masks and enable
        ctrl_word = 10'(C_AC | C_B | C_OR);
        fire(0); tick(3); expect_det("R5 antenna A masked", 0, 0);
        ctrl_word = 10'(C_A | C_B | C_OR);
        fire(2); tick(3); expect_det("R5 auto-corr disabled", 0, 0);
        tick(10);

        // R4 AND mode
        ctrl_word = 10'(C_AC | C_A | C_B);
        fire(0); tick(6); fire(1); tick(2); expect_det("R4 spacing 7", 1, 1);
        release_busy();
        fire(0); tick(7); fire(1); tick(2); expect_det("R4 spacing 8", 0, 0);
        tick(10);
        fire(2); tick(2); expect_det("R4 same sample", 1, 1);
        release_busy();
        ctrl_word = 10'(C_AC | C_A);
        fire(2); tick(3); expect_det("R4 AND with B masked", 0, 0);
        tick(10);

        // R6 energy and external sources
        ctrl_word = 10'(C_EN);
        fire(4); tick(2); expect_det("R6 ext without enable", 0, 0);
        fire(3); tick(2); expect_det("R6 energy", 1, 1);
        release_busy();
        ctrl_word = 10'(C_EXT);
        fire(3); tick(2); expect_det("R6 energy without enable", 0, 0);
        fire(4); tick(2); expect_det("R6 external", 1, 1);
        release_busy();

        // R7 ignore all
        ctrl_word = 10'(C_AC | C_A | C_B | C_OR | C_EN | C_EXT | C_IGN);
        fire(2); fire(3); fire(4); tick(3); expect_det("R7 ignore", 0, 0);
        tick(10);

        // R8 one confirmation
        ctrl_word = 10'(C_AC | C_A | C_B | C_OR);
        lc_need_one = 1;
        fire(5); tick(3); expect_det("R8 lc while idle", 0, 0);
        fire(0); tick(2); expect_det("R8 candidate pending", 0, 0);
        fire(5); tick(2); expect_det("R8 confirmed", 1, 1);
        release_busy();

        // R9 two confirmations
        lc_need_one = 0; lc_need_two = 1;
        fire(0); fire(5); tick(2); expect_det("R9 one of two", 0, 0);
        fire(5); tick(2); expect_det("R9 two of two", 1, 1);
        release_busy();

        // R10 timeout window
        lc_need_two = 0; lc_need_one = 1;
        fire(0); tick(255); fire(5); tick(2); expect_det("R10 last sample", 1, 1);
        release_busy();
        fire(0); tick(256); fire(5); tick(2); expect_det("R10 expired", 0, 0);
        tick(10);

        // R11 single pulse, busy hold
        lc_need_one = 0;
        ctrl_word = 10'(C_AC | C_A | C_B | C_OR | C_EXT);
        fire(0); tick(2); fire(1); fire(4); tick(20);
        expect_det("R11 single pulse while busy", 1, 1);
        rx_done = 1; @(negedge clk); rx_done = 0;
        expect_det("R11 released by done", 0, 0);
        tick(10);

        // R12 master reset
        fire(0); tick(2); expect_det("R12 busy before clear", 1, 1);
        ctrl_word = ctrl_word | 10'(C_MR); tick(1);
        expect_det("R12 cleared", 0, 0);
        fire(2); tick(2); expect_det("R12 held in clear", 0, 0);
        ctrl_word = 10'(C_AC | C_A | C_B | C_OR);
        tick(5);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule